// File: doc/BRIEF.md
# Interrupt Flag Register Bank

This block holds the pending-interrupt flags of a small microcontroller that contains a USB function. The flags are split across two 8-bit registers. Every flag is raised by a single-cycle hardware event pulse. The sources are timer overflows, a capture event, a falling edge on an external pin, USB token completions and handshake results, and fault conditions. A raised flag stays set until one of two things clears it: the interrupt controller acknowledges that flag, or the CPU writes a zero to its bit.

The CPU reads and writes the two registers through a plain address/data port. Writing a one to a bit leaves that bit unchanged, so software can clear selected flags without a read-modify-write race. The full flag set is also driven out as a registered vector for the interrupt controller.

The setup-overwrite flag is delayed. A SETUP that overwrites data still waiting in the endpoint-0 FIFO only arms an internal marker. The flag itself rises when a later IN or OUT token arrives while the marker is armed.

Top module: `irq_flag_bank`

## Requirements
- R1: After the hardware reset (`rstN` low), all flags and both readable registers are 0.
- R2: A cycle with `usbRst` high clears every flag and the internal overwrite marker at that clock edge, overriding any event in the same cycle.
- R3: The low register (address 0xDA) holds timer-0 overflow at bit 1, timer-1 overflow at bit 3 and capture at bit 4. The high register (address 0xDB) holds SETUP done at bit 0, OUT0 sequence error at bit 2, IN0 done at bit 3 and OUT0 done at bit 4. Each flag sets at the clock edge where its event pulse is high. `irqFlags[7:0]` carries the low register and `irqFlags[15:8]` carries the high register.
- R4: Low bit 0 sets when `extPin` was 1 at the previous edge and is 0 at the current edge. A rising edge or a steady level does not set it.
- R5: High bit 5 sets when any bit of `hsNak`, `hsAck` or `hsStall` is high. `hsNak` bits are OUT0, IN0, IN1, IN2 (bit 0 to 3). `hsAck` bits are IN1, IN2. `hsStall` bits are IN0, OUT0.
- R6: High bit 6 sets on `fnBadAddr` or on `fnBusIdle`.
- R7: `setupOverwrite` arms a marker. High bit 1 sets on a `tokenInOut` in a later cycle while the marker is armed, and that clears the marker. A token in the same cycle as the overwrite, or a token after the marker was consumed, does not set the flag.
- R8: A write to 0xDA or 0xDB clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A write to any other address changes nothing.
- R9: `ack[i]` high clears flag `i` of `irqFlags` at that edge.
- R10: When a set event and a clear (acknowledge or write of 0) hit the same flag in the same cycle, the flag ends up set.
- R11: Reserved bits (low bits 7:5 and 2, high bit 7) read 0 and ignore events and writes. A read of any address other than 0xDA or 0xDB returns 0.
- R12: `busRdData` returns the register selected by `busAddr` combinationally. A read has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| usbRst | input | 1 | Synchronous USB bus reset, active high |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data (0 clears, 1 keeps) |
| busRdData | output | 8 | Read data of the addressed register |
| tmr0Ovf | input | 1 | Timer-0 overflow pulse |
| tmr1Ovf | input | 1 | Timer-1 overflow pulse |
| capEvt | input | 1 | Capture-0 event pulse |
| extPin | input | 1 | Synchronized external interrupt pin level |
| fnBadAddr | input | 1 | Invalid program address pulse |
| fnBusIdle | input | 1 | USB bus idle timeout pulse |
| out0Done | input | 1 | OUT token on endpoint 0 completed |
| in0Done | input | 1 | IN token on endpoint 0 completed |
| setupDone | input | 1 | SETUP token on endpoint 0 completed |
| out0SeqErr | input | 1 | OUT0 data with wrong sequence bit |
| hsNak | input | 4 | NAK returned to OUT0, IN0, IN1, IN2 |
| hsAck | input | 2 | ACK returned to IN1, IN2 |
| hsStall | input | 2 | STALL returned to IN0, OUT0 |
| setupOverwrite | input | 1 | SETUP overwrote pending endpoint-0 FIFO data |
| tokenInOut | input | 1 | An IN or OUT token arrived |
| ack | input | 16 | Per-flag service acknowledge |
| irqFlags | output | 16 | Registered flag vector |

## Verification
Most faults in this block show at the ports at the first clock edge after the stimulus. A wrong write-mask polarity, a lost set-over-clear priority, a misplaced bit or a stuck reserved bit changes `irqFlags` and the readback at that edge.

The overwrite marker is the only hidden state, so a fault there surfaces later. It appears on the next `tokenInOut`: a stale marker raises high bit 1 when it should stay clear, and a lost marker leaves the bit low. For that reason the bench places a token after every marker-affecting event, including a USB reset.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int REG_W  = 8;
  localparam int FLAG_W = 2 * REG_W;

  // flag positions within the combined vector {high, low}
  localparam int B_EXT   = 0;
  localparam int B_TMR0  = 1;
  localparam int B_TMR1  = 3;
  localparam int B_CAP   = 4;
  localparam int B_SETUP = REG_W + 0;
  localparam int B_OWR   = REG_W + 1;
  localparam int B_SEQ   = REG_W + 2;
  localparam int B_IN0   = REG_W + 3;
  localparam int B_OUT0  = REG_W + 4;
  localparam int B_SIE   = REG_W + 5;
  localparam int B_FN    = REG_W + 6;

  localparam logic [FLAG_W-1:0] FLAG_MASK = 16'h7F1B;

  typedef struct packed {
    logic [FLAG_W-1:0] setVec;
    logic [FLAG_W-1:0] clrVec;
    logic              wipe;
    logic              selLo;
    logic              selHi;
  } strobes_t;
endpackage

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'hDA,
  parameter logic [7:0] ADDR_HI = 8'hDB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbRst,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              tmr0Ovf,
  input  logic              tmr1Ovf,
  input  logic              capEvt,
  input  logic              extPin,
  input  logic              fnBadAddr,
  input  logic              fnBusIdle,
  input  logic              out0Done,
  input  logic              in0Done,
  input  logic              setupDone,
  input  logic              out0SeqErr,
  input  logic [3:0]        hsNak,
  input  logic [1:0]        hsAck,
  input  logic [1:0]        hsStall,
  input  logic              setupOverwrite,
  input  logic              tokenInOut,
  input  logic [FLAG_W-1:0] ack,
  output strobes_t          stb
);
  logic extPrev;
  logic owMark;
  logic extFall;
  logic owFire;
  logic hitLo, hitHi;
  logic [FLAG_W-1:0] wrClr;
  logic [FLAG_W-1:0] rawSet;

  // pin history for falling-edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       extPrev <= 1'b0;
    else if (usbRst) extPrev <= 1'b0;
    else             extPrev <= extPin;
  end

  assign extFall = extPrev & ~extPin;

  // overwrite marker: armed by an overwriting SETUP, consumed by a later token
  assign owFire = owMark & tokenInOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       owMark <= 1'b0;
    else if (usbRst) owMark <= 1'b0;
    else             owMark <= setupOverwrite | (owMark & ~tokenInOut);
  end

  assign hitLo = (busAddr == ADDR_LO);
  assign hitHi = (busAddr == ADDR_HI);

  always_comb begin
    wrClr = '0;
    if (busWrEn && hitLo) wrClr[REG_W-1:0]      = ~busWrData;
    if (busWrEn && hitHi) wrClr[FLAG_W-1:REG_W] = ~busWrData;
  end

  always_comb begin
    rawSet          = '0;
    rawSet[B_EXT]   = extFall;
    rawSet[B_TMR0]  = tmr0Ovf;
    rawSet[B_TMR1]  = tmr1Ovf;
    rawSet[B_CAP]   = capEvt;
    rawSet[B_SETUP] = setupDone;
    rawSet[B_OWR]   = owFire;
    rawSet[B_SEQ]   = out0SeqErr;
    rawSet[B_IN0]   = in0Done;
    rawSet[B_OUT0]  = out0Done;
    rawSet[B_SIE]   = (|hsNak) | (|hsAck) | (|hsStall);
    rawSet[B_FN]    = fnBadAddr | fnBusIdle;
  end

  assign stb.setVec = rawSet & FLAG_MASK;
  assign stb.clrVec = (ack | wrClr) & FLAG_MASK;
  assign stb.wipe   = usbRst;
  assign stb.selLo  = hitLo;
  assign stb.selHi  = hitHi;
endmodule

// File: rtl/irqf_data.sv
module irqf_data
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  output logic [FLAG_W-1:0] flags,
  output logic [REG_W-1:0]  rdData
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         q <= 1'b0;
        else if (stb.wipe) q <= 1'b0;
        else               q <= stb.setVec[i] | (q & ~stb.clrVec[i]);
      end
      assign flags[i] = q;
    end else begin : g_rsvd
      assign flags[i] = 1'b0;
    end
  end

  always_comb begin
    if (stb.selLo)      rdData = flags[REG_W-1:0];
    else if (stb.selHi) rdData = flags[FLAG_W-1:REG_W];
    else                rdData = '0;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irqf_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'hDA,
  parameter logic [7:0] ADDR_HI = 8'hDB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbRst,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic              tmr0Ovf,
  input  logic              tmr1Ovf,
  input  logic              capEvt,
  input  logic              extPin,
  input  logic              fnBadAddr,
  input  logic              fnBusIdle,
  input  logic              out0Done,
  input  logic              in0Done,
  input  logic              setupDone,
  input  logic              out0SeqErr,
  input  logic [3:0]        hsNak,
  input  logic [1:0]        hsAck,
  input  logic [1:0]        hsStall,
  input  logic              setupOverwrite,
  input  logic              tokenInOut,
  input  logic [FLAG_W-1:0] ack,
  output logic [FLAG_W-1:0] irqFlags
);
  strobes_t stb;

  irqf_ctrl #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .usbRst(usbRst),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .capEvt(capEvt), .extPin(extPin),
    .fnBadAddr(fnBadAddr), .fnBusIdle(fnBusIdle),
    .out0Done(out0Done), .in0Done(in0Done), .setupDone(setupDone),
    .out0SeqErr(out0SeqErr), .hsNak(hsNak), .hsAck(hsAck), .hsStall(hsStall),
    .setupOverwrite(setupOverwrite), .tokenInOut(tokenInOut),
    .ack(ack), .stb(stb)
  );

  irqf_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .flags(irqFlags), .rdData(busRdData)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
  import irqf_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'hDA,
  parameter logic [7:0] ADDR_HI = 8'hDB
) (
  input logic              clk,
  input logic              rstN,
  input logic              usbRst,
  input logic [7:0]        busAddr,
  input logic              busWrEn,
  input logic [REG_W-1:0]  busWrData,
  input logic [REG_W-1:0]  busRdData,
  input logic              tmr0Ovf,
  input logic              tmr1Ovf,
  input logic [3:0]        hsNak,
  input logic [1:0]        hsAck,
  input logic [1:0]        hsStall,
  input logic              tokenInOut,
  input logic [FLAG_W-1:0] ack,
  input logic [FLAG_W-1:0] irqFlags
);
  assert_usb_wipe_R2: assert property (@(posedge clk) disable iff (!rstN)
    usbRst |=> (irqFlags == '0));

  assert_tmr0_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tmr0Ovf && !usbRst) |=> irqFlags[B_TMR0]);

  assert_sie_any_R5: assert property (@(posedge clk) disable iff (!rstN)
    (((|hsNak) || (|hsAck) || (|hsStall)) && !usbRst) |=> irqFlags[B_SIE]);

  assert_owr_needs_token_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[B_OWR]) |-> $past(tokenInOut));

  assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_LO && busWrData[B_CAP] && irqFlags[B_CAP]
     && !ack[B_CAP] && !usbRst) |=> irqFlags[B_CAP]);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ack[B_TMR1] && !tmr1Ovf) |=> !irqFlags[B_TMR1]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tmr1Ovf && ack[B_TMR1] && !usbRst) |=> irqFlags[B_TMR1]);

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != ADDR_LO && busAddr != ADDR_HI) |-> (busRdData == '0));
endmodule

bind irq_flag_bank irqf_checker #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_chk (
  .clk(clk), .rstN(rstN), .usbRst(usbRst), .busAddr(busAddr),
  .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
  .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .hsNak(hsNak), .hsAck(hsAck),
  .hsStall(hsStall), .tokenInOut(tokenInOut), .ack(ack), .irqFlags(irqFlags)
);

// File: tb/sim_irq_flag_bank.sv
`timescale 1ns/1ps
module sim_irq_flag_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usbRst = 1'b0;
  logic [7:0] busAddr = 8'hDA;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic tmr0Ovf = 0, tmr1Ovf = 0, capEvt = 0, extPin = 0;
  logic fnBadAddr = 0, fnBusIdle = 0;
  logic out0Done = 0, in0Done = 0, setupDone = 0, out0SeqErr = 0;
  logic [3:0] hsNak = '0;
  logic [1:0] hsAck = '0, hsStall = '0;
  logic setupOverwrite = 0, tokenInOut = 0;
  logic [15:0] ack = '0;
  logic [15:0] irqFlags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] expF;
    logic [7:0]  expRd;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  irq_flag_bank u0 (
    .clk(clk), .rstN(rstN), .usbRst(usbRst), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .capEvt(capEvt), .extPin(extPin),
    .fnBadAddr(fnBadAddr), .fnBusIdle(fnBusIdle), .out0Done(out0Done),
    .in0Done(in0Done), .setupDone(setupDone), .out0SeqErr(out0SeqErr),
    .hsNak(hsNak), .hsAck(hsAck), .hsStall(hsStall),
    .setupOverwrite(setupOverwrite), .tokenInOut(tokenInOut),
    .ack(ack), .irqFlags(irqFlags)
  );

  // monitor: compares outputs shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (irqFlags !== it.expF || busRdData !== it.expRd) begin
          errors++;
          $display("FAIL %s: flags=%h exp %h rd=%h exp %h",
                   it.tag, irqFlags, it.expF, busRdData, it.expRd);
        end
      end
    end
  end

  // driver: one clock with the current stimulus, expectation queued
  task automatic tick(input string tag, input logic [15:0] expF, input logic [7:0] expRd);
    @(posedge clk);
    sb.push_back('{expF, expRd, tag});
    @(negedge clk);
    tmr0Ovf = 0; tmr1Ovf = 0; capEvt = 0; fnBadAddr = 0; fnBusIdle = 0;
    out0Done = 0; in0Done = 0; setupDone = 0; out0SeqErr = 0;
    hsNak = '0; hsAck = '0; hsStall = '0;
    setupOverwrite = 0; tokenInOut = 0; ack = '0;
    busWrEn = 0; usbRst = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick("R1 reset state", 16'h0000, 8'h00);

    tmr0Ovf = 1; tmr1Ovf = 1; capEvt = 1;
    tick("R3 low events", 16'h001A, 8'h1A);
    busAddr = 8'hDB;
    out0Done = 1; in0Done = 1; out0SeqErr = 1; setupDone = 1;
    tick("R3 high events", 16'h1D1A, 8'h1D);

    busWrEn = 1; busWrData = 8'hFF;
    tick("R8 write ones keep", 16'h1D1A, 8'h1D);
    busWrEn = 1; busWrData = 8'hEB;
    tick("R8 write zero clears", 16'h091A, 8'h09);
    busAddr = 8'h10; busWrEn = 1; busWrData = 8'h00;
    tick("R8 R11 other address", 16'h091A, 8'h00);

    busAddr = 8'hDA; ack = 16'h0102;
    tick("R9 ack clears", 16'h0818, 8'h18);
    busWrEn = 1; busWrData = 8'h00; tmr1Ovf = 1;
    ack[11] = 1'b1; in0Done = 1;
    tick("R10 set beats clear", 16'h0808, 8'h08);

    extPin = 1;
    tick("R4 rising no set", 16'h0808, 8'h08);
    tick("R4 high level", 16'h0808, 8'h08);
    extPin = 0;
    tick("R4 falling sets", 16'h0809, 8'h09);
    tick("R4 low level", 16'h0809, 8'h09);

    busAddr = 8'hDB;
    for (int k = 0; k < 8; k++) begin
      if (k < 4) hsNak[k] = 1'b1;
      else if (k < 6) hsAck[k-4] = 1'b1;
      else hsStall[k-6] = 1'b1;
      tick("R5 handshake sets", 16'h2809, 8'h28);
      ack[13] = 1'b1;
      tick("R5 R9 ack", 16'h0809, 8'h08);
    end

    fnBadAddr = 1;
    tick("R6 bad address", 16'h4809, 8'h48);
    ack[14] = 1'b1;
    tick("R6 ack", 16'h0809, 8'h08);
    fnBusIdle = 1;
    tick("R6 bus idle", 16'h4809, 8'h48);
    ack[14] = 1'b1;
    tick("R6 ack", 16'h0809, 8'h08);

    setupOverwrite = 1; tokenInOut = 1;
    tick("R7 same cycle no set", 16'h0809, 8'h08);
    tokenInOut = 1;
    tick("R7 later token sets", 16'h0A09, 8'h0A);
    ack[9] = 1'b1;
    tick("R7 ack", 16'h0809, 8'h08);
    tokenInOut = 1;
    tick("R7 marker consumed", 16'h0809, 8'h08);
    tick("R12 read no side effect", 16'h0809, 8'h08);

    setupOverwrite = 1;
    tick("R7 arm", 16'h0809, 8'h08);
    usbRst = 1; tmr0Ovf = 1;
    tick("R2 usb reset", 16'h0000, 8'h00);
    tokenInOut = 1;
    tick("R2 marker cleared", 16'h0000, 8'h00);

    out0Done = 1; in0Done = 1; setupDone = 1; out0SeqErr = 1;
    hsNak[0] = 1'b1; fnBadAddr = 1;
    tick("R11 R12 high all", 16'h7D00, 8'h7D);
    busAddr = 8'hDA; tmr0Ovf = 1; tmr1Ovf = 1; capEvt = 1;
    tick("R11 low reserved zero", 16'h7D1A, 8'h1A);
    ack = 16'hFFFF;
    tick("R9 ack all", 16'h0000, 8'h00);

    @(posedge clk);
    #4;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule